// File: doc/BRIEF.md
# Clickless Stereo Digital Attenuator

This block scales a stereo stream of 24-bit two's-complement samples by a linear gain that is set separately for the left and right channels. Each gain is a 14-bit word, so the scale has 16384 steps, and the word 16383 counts as unity. Software writes the two target gains and a soft-mute bit through a small write port. A hardware mute pin can also silence the stream. When a target changes or mute is asserted, the gain actually applied to the samples does not jump. It moves one step per sample strobe until it reaches the new value, so the output never shows a step discontinuity.

Each channel has its own ramp controller. Its state machine has three states. `RS_HOLD` means the applied gain equals the effective target. `RS_RISE` means the applied gain is below the target. `RS_FALL` means it is above. The transitions are:

- HOLD to RISE: the target moves above the applied gain.
- HOLD to FALL: the target moves below the applied gain.
- RISE to HOLD and FALL to HOLD: the applied gain reaches the target.
- RISE to FALL and FALL to RISE: a new write reverses the direction mid-ramp.

While mute is in force, the effective target is zero. When mute is released, the effective target returns to the stored word.

Top module: `stereo_atten`

## Requirements
- R1: After reset, both target gains and both applied gains are 16383, the soft-mute bit is clear, `out_left`, `out_right` and `out_valid` are 0, and `ramp_active` is low.
- R2: A write with `wr_addr` = 0 loads `wr_data` into the left target gain, and `wr_addr` = 1 loads the right target gain. The channels are independent, so a write to one never alters the other.
- R3: A write with `wr_addr` = 2 sets the soft-mute bit to `wr_data[0]`. A write with `wr_addr` = 3 has no effect on any gain, on mute, or on the output.
- R4: On each clock with `in_valid` high, each channel's applied gain moves by exactly one toward its effective target, or stays put if it already matches. Without `in_valid`, the applied gain is unchanged.
- R5: Mute is the OR of `hw_mute`, delayed by one register stage, and the soft-mute bit. While mute is in force, the effective target is 0. After mute is released, the applied gain ramps back to the stored target.
- R6: One clock after `in_valid`, `out_valid` pulses and each output equals floor(sample × g / 16384), where g is the applied gain before that strobe's step. When g = 16383, the sample passes through unchanged. Outputs hold their value between strobes.
- R7: `ramp_active` is registered. After each clock edge, it is high exactly when either channel's applied gain, as updated at that edge, differs from the effective target that was in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 left gain, 1 right gain, 2 soft mute, 3 unused |
| wr_data | input | 14 | Write data |
| hw_mute | input | 1 | Hardware mute request |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| ramp_active | output | 1 | An applied gain is still moving toward its target |

## Verification
The assertions assume that the write port carries at most one write per clock and that `hw_mute` is already synchronous to `clk`. They also assume that the strobe alone decides when a gain may move. The stimulus changes every input only on the falling edge. It keeps `wr_en` to single-cycle pulses and mixes back-to-back strobes with idle gaps. It reverses a target mid-ramp and holds mute long enough for the applied gain to reach zero before releasing it.

// File: rtl/atten_pkg.sv
package atten_pkg;

    typedef enum logic [1:0] {
        RS_HOLD = 2'd0,
        RS_RISE = 2'd1,
        RS_FALL = 2'd2
    } ramp_state_e;

    typedef enum logic [1:0] {
        REG_GAIN_L = 2'd0,
        REG_GAIN_R = 2'd1,
        REG_MUTE   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/atten_regs.sv
module atten_regs
    import atten_pkg::*;
#(
    parameter int GAIN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [GAIN_W-1:0] wr_data,
    input  logic              hw_mute,
    output logic [GAIN_W-1:0] tgt_l_o,
    output logic [GAIN_W-1:0] tgt_r_o,
    output logic              mute_o
);
    localparam logic [GAIN_W-1:0] GAIN_FULL = {GAIN_W{1'b1}};

    logic [GAIN_W-1:0] tgt_l_q, tgt_r_q;
    logic              soft_mute_q, hw_mute_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_l_q     <= GAIN_FULL;
            tgt_r_q     <= GAIN_FULL;
            soft_mute_q <= 1'b0;
            hw_mute_q   <= 1'b0;
        end else begin
            hw_mute_q <= hw_mute;
            if (wr_en) begin
                case (reg_sel_e'(wr_addr))
                    REG_GAIN_L: tgt_l_q     <= wr_data;
                    REG_GAIN_R: tgt_r_q     <= wr_data;
                    REG_MUTE:   soft_mute_q <= wr_data[0];
                    default:    ;
                endcase
            end
        end
    end

    assign tgt_l_o = tgt_l_q;
    assign tgt_r_o = tgt_r_q;
    assign mute_o  = hw_mute_q | soft_mute_q;

    p_left_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (tgt_l_o == $past(wr_data) && $stable(tgt_r_o)));

    p_spare_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ($stable(tgt_l_o) && $stable(tgt_r_o) && $stable(soft_mute_q)));

endmodule

// File: rtl/gain_ramp.sv
module gain_ramp
    import atten_pkg::*;
#(
    parameter int GAIN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [GAIN_W-1:0] tgt_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              ramp_o
);
    localparam logic [GAIN_W-1:0] GAIN_FULL = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] ONE_STEP  = GAIN_W'(1);

    function automatic ramp_state_e classify(input logic [GAIN_W-1:0] cur,
                                             input logic [GAIN_W-1:0] tgt);
        if (cur < tgt)      return RS_RISE;
        else if (cur > tgt) return RS_FALL;
        else                return RS_HOLD;
    endfunction

    ramp_state_e       st_q, st_d;
    logic [GAIN_W-1:0] gain_q, gain_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RS_HOLD;
            gain_q <= GAIN_FULL;
        end else begin
            st_q   <= st_d;
            gain_q <= gain_d;
        end
    end

    always_comb begin
        gain_d = gain_q;
        if (strobe_i) begin
            unique case (classify(gain_q, tgt_i))
                RS_RISE: gain_d = gain_q + ONE_STEP;
                RS_FALL: gain_d = gain_q - ONE_STEP;
                RS_HOLD: gain_d = gain_q;
                default: gain_d = gain_q;
            endcase
        end
        st_d = classify(gain_d, tgt_i);
    end

    assign gain_o = gain_q;
    assign ramp_o = (st_q != RS_HOLD);

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q != $past(gain_q)) |->
            ($past(strobe_i) && (gain_q == $past(gain_q) + ONE_STEP ||
                                 gain_q == $past(gain_q) - ONE_STEP)));

    p_mute_descends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && tgt_i == '0 && gain_q != '0) |=> (gain_q == $past(gain_q) - ONE_STEP));

endmodule

// File: rtl/gain_scale.sv
module gain_scale #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [GAIN_W-1:0]   gain_i,
    output logic [SAMPLE_W-1:0] out_o
);
    localparam int                PROD_W    = SAMPLE_W + GAIN_W;
    localparam logic [GAIN_W-1:0] GAIN_FULL = {GAIN_W{1'b1}};

    logic signed [PROD_W-1:0]   prod;
    logic        [SAMPLE_W-1:0] scaled;
    logic        [SAMPLE_W-1:0] out_q;

    always_comb begin
        prod   = $signed(sample_i) * $signed({1'b0, gain_i});
        scaled = SAMPLE_W'(prod >>> GAIN_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_q <= '0;
        else if (strobe_i) out_q <= (gain_i == GAIN_FULL) ? sample_i : scaled;
    end

    assign out_o = out_q;

    p_unity_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && gain_i == GAIN_FULL) |=> (out_o == $past(sample_i)));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(out_o));

endmodule

// File: rtl/stereo_atten.sv
module stereo_atten #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [GAIN_W-1:0]   wr_data,
    input  logic                hw_mute,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                ramp_active
);
    localparam int N_CH = 2;

    logic [GAIN_W-1:0]   tgt   [N_CH];
    logic [GAIN_W-1:0]   eff   [N_CH];
    logic [GAIN_W-1:0]   gain  [N_CH];
    logic [SAMPLE_W-1:0] samp  [N_CH];
    logic [SAMPLE_W-1:0] res   [N_CH];
    logic [N_CH-1:0]     ramp;
    logic                mute;
    logic                valid_q;

    atten_regs #(.GAIN_W(GAIN_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hw_mute (hw_mute),
        .tgt_l_o (tgt[0]),
        .tgt_r_o (tgt[1]),
        .mute_o  (mute)
    );

    assign samp[0] = in_left;
    assign samp[1] = in_right;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        assign eff[ch] = mute ? '0 : tgt[ch];

        gain_ramp #(.GAIN_W(GAIN_W)) ramp_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (in_valid),
            .tgt_i    (eff[ch]),
            .gain_o   (gain[ch]),
            .ramp_o   (ramp[ch])
        );

        gain_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) scale_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (in_valid),
            .sample_i (samp[ch]),
            .gain_i   (gain[ch]),
            .out_o    (res[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    assign out_valid   = valid_q;
    assign out_left    = res[0];
    assign out_right   = res[1];
    assign ramp_active = |ramp;

    p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: tb/stereo_atten_tb_top.sv
`timescale 1ns/1ps
module stereo_atten_tb_top;
    localparam int GMAX = 16383;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic        hw_mute = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic        out_valid, ramp_active;
    logic [23:0] out_left, out_right;

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string tag = "R1";

    always #4 clk = ~clk;

    stereo_atten dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hw_mute(hw_mute), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .ramp_active(ramp_active)
    );

    // behavioural reference model
    int m_tl, m_tr, m_al, m_ar, m_ol, m_or;
    bit m_sw, m_hwq, m_ov, m_ramp;

    function automatic int step_to(int a, int t);
        if (a < t) return a + 1;
        if (a > t) return a - 1;
        return a;
    endfunction

    function automatic int scale(logic [23:0] s, int g);
        longint p;
        if (g == GMAX) return int'($signed(s));
        p = longint'($signed(s)) * longint'(g);
        return int'(p >>> 14);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tl <= GMAX; m_tr <= GMAX; m_al <= GMAX; m_ar <= GMAX;
            m_ol <= 0; m_or <= 0; m_sw <= 0; m_hwq <= 0; m_ov <= 0; m_ramp <= 0;
        end else begin
            int el, er, nl, nr;
            bit mu;
            mu = m_hwq | m_sw;
            el = mu ? 0 : m_tl;
            er = mu ? 0 : m_tr;
            nl = m_al; nr = m_ar;
            if (in_valid) begin
                m_ol <= scale(in_left, m_al);
                m_or <= scale(in_right, m_ar);
                nl = step_to(m_al, el);
                nr = step_to(m_ar, er);
            end
            m_al <= nl; m_ar <= nr;
            m_ov <= in_valid;
            m_ramp <= (nl != el) || (nr != er);
            m_hwq <= hw_mute;
            if (wr_en) begin
                if (wr_addr == 2'd0) m_tl <= int'(wr_data);
                else if (wr_addr == 2'd1) m_tr <= int'(wr_data);
                else if (wr_addr == 2'd2) m_sw <= wr_data[0];
            end
        end
    end

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check({tag, "/R6"}, "out_valid", int'(out_valid), int'(m_ov));
            check({tag, "/R6"}, "out_left", int'($signed(out_left)), m_ol);
            check({tag, "/R6"}, "out_right", int'($signed(out_right)), m_or);
            check({tag, "/R7"}, "ramp_active", int'(ramp_active), int'(m_ramp));
        end
    end

    task automatic write_reg(logic [1:0] a, logic [13:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobes(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_left  = 24'($urandom);
            in_right = 24'($urandom);
            @(negedge clk);
            in_valid = 1'b0;
            if (gaps && (i % 3 == 1)) @(negedge clk);
        end
    endtask

    task automatic one_sample(logic [23:0] l, logic [23:0] r);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got 1 exp 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen at the ports
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "out_left", int'(out_left), 0);
        check("R1", "out_right", int'(out_right), 0);
        check("R1", "ramp_active", int'(ramp_active), 0);
        cmp_on = 1'b1;

        tag = "R6";
        strobes(16, 1'b0);
        one_sample(24'h7FFFFF, 24'h800000);
        one_sample(24'h800000, 24'h7FFFFF);
        @(negedge clk);
        check("R6", "idle hold out_right", int'($signed(out_right)), 8388607);

        tag = "R2";
        write_reg(2'd0, 14'd16370);
        write_reg(2'd1, 14'd16383);
        strobes(24, 1'b1);

        tag = "R4";
        write_reg(2'd0, 14'd8000);
        write_reg(2'd1, 14'd2000);
        repeat (4) @(negedge clk);
        strobes(16400, 1'b0);

        tag = "R5";
        hw_mute = 1'b1;
        strobes(8100, 1'b0);
        one_sample(24'h7FFFFF, 24'h800000);
        @(negedge clk);
        check("R5", "muted out_left", int'($signed(out_left)), 0);
        check("R5", "muted out_right", int'($signed(out_right)), 0);
        hw_mute = 1'b0;
        strobes(8100, 1'b0);

        tag = "R3";
        write_reg(2'd2, 14'd1);
        strobes(50, 1'b1);
        write_reg(2'd3, 14'd5);
        strobes(10, 1'b0);
        write_reg(2'd2, 14'd0);
        strobes(60, 1'b0);

        tag = "R7";
        write_reg(2'd0, 14'd8030);
        strobes(10, 1'b1);
        write_reg(2'd0, 14'd7990);
        strobes(60, 1'b1);
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule